// File: doc/BRIEF.md
# Programmable SPI Master with Word FIFOs

This block is a memory-mapped serial peripheral master. Software programs a control word that sets the clock polarity and phase, the word length and a power-of-two clock divider. It pushes transmit words into a 16-entry FIFO and pops captured words from a second 16-entry FIFO. The shift engine sends each queued word most significant bit first on the data-out line and samples the data-in line in the same word slot. Every word it sends therefore leaves exactly one received word behind.

The chip select line is a plain register bit under software control. The host side is a simple synchronous register port. A read has its data on `rdata` in the same cycle as the request, and a read of the receive location removes the word at the clock edge. Words that are already queued go out back to back with no idle serial clock between them. When the transmit queue is empty, the serial clock rests at its programmed idle level.

Top module: `spim_top`

## Requirements
- R1: After reset the status register (address 3) reads 0x4, which means only the transmit-empty bit is set. The control register (address 2) reads 0. `cs_n` is 1, and `sclk` and `mosi` are 0.
- R2: The divider field in control bits [7:5] sets the serial clock period to 2^(div+2) system clocks. Each clock half lasts 2^(div+1) cycles.
- R3: When no word is being shifted, `sclk` stays at the polarity bit (control bit 3). It returns to that level after the last word drains.
- R4: Control bit 4 selects the phase. With the bit at 0, `mosi` changes on trailing edges and `miso` is sampled on leading edges. With the bit at 1, `mosi` changes on leading edges and `miso` is sampled on trailing edges. Both are most significant bit first. A leading edge is one that leaves the idle level.
- R5: Control bits [12:8] hold the word length minus one, which gives 1 to 32 bits. Only the low bits of a transmit word are sent. The received word is right-aligned and its upper bits are zero.
- R6: When n words are queued before enable is set, the time from the first to the last `sclk` edge is (2·N·n−1)·2^(div+1) system clocks, where N is the word length.
- R7: Each transmitted word produces one receive FIFO entry. Status bit 0 is 1 while the receive FIFO holds a word. A read of address 1 returns the oldest word and removes it.
- R8: While enable (control bit 0) is 0, no word is started. `sclk` stays idle, and queued words remain in the transmit FIFO.
- R9: A write to address 0 pushes a word into the transmit FIFO. If the FIFO already holds 16 words, the write is dropped and sticky status bit 4 is set. Writing 1 to status bit 4 clears it. Status bit 1 shows that the transmit FIFO is full.
- R10: A read of address 1 while the receive FIFO is empty returns 0 and sets sticky status bit 5. Writing 1 to status bit 5 clears it.
- R11: A word is not started unless its received word will have room in the receive FIFO. Status bit 3 shows that a word is being shifted. Stalled words are kept and are sent once software frees space, so no received word is lost.
- R12: Bit 0 written to address 4 drives `cs_n` directly. The bit resets to 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| addr | input | 3 | Register address |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe (pops the receive FIFO at address 1) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid in the request cycle |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | 1 | Software-driven chip select |

## Verification
A fault in the engine's edge counter or bit index shows up at the ports within one word. The bench sees it as a wrong edge span or as bits captured from `mosi` that differ from the queued word. A fault in the phase handling instead shows up as a received word shifted by one bit. A wrong divider count changes the measured first-to-last edge span as soon as a transfer completes. A FIFO pointer or room fault appears later, at the first read-back that is misordered, missing or duplicated, or as a transmit word that is lost when the receive side is full.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int DATA_W = 32;
  localparam int LEN_W  = $clog2(DATA_W);
  localparam int DIV_W  = 3;
  localparam int CNT_W  = 1 << DIV_W;
  localparam int ADDR_W = 3;

  localparam logic [ADDR_W-1:0] A_TX   = 3'd0;
  localparam logic [ADDR_W-1:0] A_RX   = 3'd1;
  localparam logic [ADDR_W-1:0] A_CTRL = 3'd2;
  localparam logic [ADDR_W-1:0] A_STAT = 3'd3;
  localparam logic [ADDR_W-1:0] A_CS   = 3'd4;

  localparam int ST_RDY    = 0;
  localparam int ST_TXFULL = 1;
  localparam int ST_TXEMP  = 2;
  localparam int ST_BUSY   = 3;
  localparam int ST_OVF    = 4;
  localparam int ST_UDF    = 5;

  typedef struct packed {
    logic [LEN_W-1:0] len_m1;
    logic [DIV_W-1:0] div;
    logic             cpha;
    logic             cpol;
    logic             pio;
    logic             master;
    logic             enable;
  } ctrl_t;

  localparam int CTRL_W = $bits(ctrl_t);

  // last count value of one clock half: 2^(div+1) - 1
  function automatic logic [CNT_W-1:0] last_count(input logic [DIV_W-1:0] div);
    return CNT_W'((1 << (int'(div) + 1)) - 1);
  endfunction

  // index of the final edge of a word: 2*N - 1
  function automatic logic [LEN_W:0] last_edge(input logic [LEN_W-1:0] len_m1);
    return {len_m1, 1'b1};
  endfunction

  // mask of the N low bits of a word
  function automatic logic [DATA_W-1:0] word_mask(input logic [LEN_W-1:0] len_m1);
    logic [DATA_W-1:0] ones;
    ones = '1;
    return ones >> ((DATA_W - 1) - int'(len_m1));
  endfunction
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int W     = 32,
  parameter int DEPTH = 16
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       push,
  input  logic [W-1:0]               din,
  input  logic                       pop,
  output logic [W-1:0]               dout,
  output logic                       full,
  output logic                       empty,
  output logic [$clog2(DEPTH):0]     count
);
  localparam int PTR_W = $clog2(DEPTH);

  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wp_q, rp_q;
  logic [PTR_W:0]   cnt_q;

  assign full  = (cnt_q == (PTR_W+1)'(DEPTH));
  assign empty = (cnt_q == '0);
  assign count = cnt_q;
  assign dout  = mem_q[rp_q];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (push) begin
        wp_q <= (wp_q == PTR_W'(DEPTH - 1)) ? '0 : wp_q + 1'b1;
      end
      if (pop) begin
        rp_q <= (rp_q == PTR_W'(DEPTH - 1)) ? '0 : rp_q + 1'b1;
      end
      case ({push, pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem_q[wp_q] <= din;
  end

  // R7: the consumer never removes a word that is not there
  a_r7_no_pop_empty: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
  // R9: the producer never pushes past capacity
  a_r9_no_push_full: assert property (@(posedge clk) disable iff (!rst_n)
    push && !pop |-> !full);
endmodule

// File: rtl/spim_tick.sv
module spim_tick import spim_pkg::*; (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             run,
  input  logic [DIV_W-1:0] div,
  output logic             tick
);
  logic [CNT_W-1:0] cnt_q;

  assign tick = run && (cnt_q == last_count(div));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          cnt_q <= '0;
    else if (!run || tick) cnt_q <= '0;
    else                 cnt_q <= cnt_q + 1'b1;
  end

  // R2: a clock half never runs past its programmed length
  a_r2_half_bound: assert property (@(posedge clk) disable iff (!rst_n)
    run |-> cnt_q <= last_count(div));
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter import spim_pkg::*; (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start_ok,
  input  logic              cfg_cpol,
  input  logic              cfg_cpha,
  input  logic [DIV_W-1:0]  cfg_div,
  input  logic [LEN_W-1:0]  cfg_len_m1,
  input  logic [DATA_W-1:0] tx_word,
  input  logic              miso,
  output logic              load,
  output logic              done,
  output logic              busy,
  output logic [DATA_W-1:0] rx_word,
  output logic              sclk,
  output logic              mosi
);
  logic              busy_q, sclk_q, mosi_q, lat_cpha;
  logic [DIV_W-1:0]  lat_div;
  logic [LEN_W-1:0]  lat_len, bidx_q, bidx_dn;
  logic [LEN_W:0]    edge_q;
  logic [DATA_W-1:0] txw_q, rxsh_q;
  logic              tick, leading, at_last;

  spim_tick u_tick (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy_q),
    .div  (lat_div),
    .tick (tick)
  );

  assign leading = !edge_q[0];
  assign at_last = (edge_q == last_edge(lat_len));
  assign done    = busy_q && tick && at_last;
  assign load    = start_ok && (!busy_q || done);
  assign bidx_dn = bidx_q - 1'b1;
  assign rx_word = word_mask(lat_len) &
                   (lat_cpha ? {rxsh_q[DATA_W-2:0], miso} : rxsh_q);
  assign busy    = busy_q;
  assign sclk    = sclk_q;
  assign mosi    = mosi_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy_q   <= 1'b0;
      sclk_q   <= 1'b0;
      mosi_q   <= 1'b0;
      lat_cpha <= 1'b0;
      lat_div  <= '0;
      lat_len  <= '0;
      bidx_q   <= '0;
      edge_q   <= '0;
      txw_q    <= '0;
      rxsh_q   <= '0;
    end else begin
      if (busy_q && tick) begin
        sclk_q <= ~sclk_q;
        edge_q <= edge_q + 1'b1;
        if (leading) begin
          if (!lat_cpha) rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
          else           mosi_q <= txw_q[bidx_q];
        end else begin
          if (!lat_cpha) begin
            if (bidx_q != '0) begin
              bidx_q <= bidx_dn;
              mosi_q <= txw_q[bidx_dn];
            end
          end else begin
            rxsh_q <= {rxsh_q[DATA_W-2:0], miso};
            bidx_q <= bidx_dn;
          end
        end
      end
      if (load) begin
        busy_q   <= 1'b1;
        edge_q   <= '0;
        lat_cpha <= cfg_cpha;
        lat_div  <= cfg_div;
        lat_len  <= cfg_len_m1;
        bidx_q   <= cfg_len_m1;
        txw_q    <= tx_word;
        rxsh_q   <= '0;
        if (!cfg_cpha) mosi_q <= tx_word[cfg_len_m1];
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (!busy_q && !load) sclk_q <= cfg_cpol;
    end
  end

  // R2: the serial clock moves only at the end of a clock half
  a_r2_sclk_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && !tick |=> $stable(sclk_q));
  // R3: idle serial clock sits at the polarity level
  a_r3_idle_level: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q && $stable(cfg_cpol) |-> sclk_q == cfg_cpol);
  // R4: in phase-0 mode data out holds across leading edges
  a_r4_hold_leading: assert property (@(posedge clk) disable iff (!rst_n)
    busy_q && tick && leading && !lat_cpha |=> $stable(mosi_q));
endmodule

// File: rtl/spim_top.sv
module spim_top import spim_pkg::*; #(
  parameter int FIFO_DEPTH = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [DATA_W-1:0] wdata,
  output logic [DATA_W-1:0] rdata,
  output logic              sclk,
  output logic              mosi,
  input  logic              miso,
  output logic              cs_n
);
  localparam int FC_W = $clog2(FIFO_DEPTH) + 1;

  ctrl_t             ctrl_q;
  logic              cs_q, ovf_q, udf_q;
  logic              tx_push, tx_full, tx_empty;
  logic              rx_pop, rx_full, rx_empty;
  logic [FC_W-1:0]   tx_cnt, rx_cnt;
  logic [DATA_W-1:0] tx_head, rx_head, rx_word;
  logic              sh_load, sh_done, sh_busy, rx_room, start_ok;
  logic              wr_tx, rd_rx, wr_stat;
  logic [DATA_W-1:0] status;

  assign wr_tx   = wr_en && (addr == A_TX);
  assign rd_rx   = rd_en && (addr == A_RX);
  assign wr_stat = wr_en && (addr == A_STAT);
  assign tx_push = wr_tx && !tx_full;
  assign rx_pop  = rd_rx && !rx_empty;

  // room for the word now finishing plus the one about to start
  assign rx_room  = ({1'b0, rx_cnt} + {{FC_W{1'b0}}, sh_done}) < (FC_W+1)'(FIFO_DEPTH);
  assign start_ok = ctrl_q.enable && !tx_empty && rx_room;

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk(clk), .rst_n(rst_n), .push(tx_push), .din(wdata),
    .pop(sh_load), .dout(tx_head), .full(tx_full), .empty(tx_empty),
    .count(tx_cnt)
  );

  spim_fifo #(.W(DATA_W), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk(clk), .rst_n(rst_n), .push(sh_done), .din(rx_word),
    .pop(rx_pop), .dout(rx_head), .full(rx_full), .empty(rx_empty),
    .count(rx_cnt)
  );

  spim_shifter u_shift (
    .clk       (clk),
    .rst_n     (rst_n),
    .start_ok  (start_ok),
    .cfg_cpol  (ctrl_q.cpol),
    .cfg_cpha  (ctrl_q.cpha),
    .cfg_div   (ctrl_q.div),
    .cfg_len_m1(ctrl_q.len_m1),
    .tx_word   (tx_head),
    .miso      (miso),
    .load      (sh_load),
    .done      (sh_done),
    .busy      (sh_busy),
    .rx_word   (rx_word),
    .sclk      (sclk),
    .mosi      (mosi)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      cs_q   <= 1'b1;
      ovf_q  <= 1'b0;
      udf_q  <= 1'b0;
    end else begin
      if (wr_en && addr == A_CTRL) ctrl_q <= ctrl_t'(wdata[CTRL_W-1:0]);
      if (wr_en && addr == A_CS)   cs_q   <= wdata[0];
      if (wr_tx && tx_full)             ovf_q <= 1'b1;
      else if (wr_stat && wdata[ST_OVF]) ovf_q <= 1'b0;
      if (rd_rx && rx_empty)            udf_q <= 1'b1;
      else if (wr_stat && wdata[ST_UDF]) udf_q <= 1'b0;
    end
  end

  always_comb begin
    status          = '0;
    status[ST_RDY]    = !rx_empty;
    status[ST_TXFULL] = tx_full;
    status[ST_TXEMP]  = tx_empty;
    status[ST_BUSY]   = sh_busy;
    status[ST_OVF]    = ovf_q;
    status[ST_UDF]    = udf_q;
  end

  always_comb begin
    case (addr)
      A_RX:    rdata = rx_empty ? '0 : rx_head;
      A_CTRL:  rdata = DATA_W'(ctrl_q);
      A_STAT:  rdata = status;
      A_CS:    rdata = DATA_W'(cs_q);
      default: rdata = '0;
    endcase
  end

  assign cs_n = cs_q;

  // R9: a write to a full transmit FIFO leaves the overflow flag set
  a_r9_ovf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    wr_tx && tx_full |=> ovf_q);
  // R10: a read of an empty receive FIFO leaves the underflow flag set
  a_r10_udf_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    rd_rx && rx_empty |=> udf_q);
  // R11: a finishing word always finds space in the receive FIFO
  a_r11_room_on_done: assert property (@(posedge clk) disable iff (!rst_n)
    sh_done |-> !rx_full);
  // R8: nothing starts while the controller is disabled
  a_r8_no_start_disabled: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_q.enable |-> !sh_load);
endmodule

// File: tb/spim_top_tb.sv
module spim_top_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  addr = '0;
  logic        wr_en = 1'b0, rd_en = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        sclk, mosi, cs_n;
  logic        miso = 1'b0;

  int checks = 0, fails = 0;
  bit finished = 0;

  always #4 clk = ~clk;

  spim_top dut_i (
    .clk(clk), .rst_n(rst_n), .addr(addr), .wr_en(wr_en), .rd_en(rd_en),
    .wdata(wdata), .rdata(rdata), .sclk(sclk), .mosi(mosi), .miso(miso),
    .cs_n(cs_n)
  );

  // ---------------- bench-side slave model ----------------
  int          s_len = 8;
  logic        s_cpol = 0, s_cpha = 0;
  bit          s_act = 0;
  int          s_drv, s_smp, s_edges, n_seen;
  time         t_first, t_last;
  logic [31:0] s_cap;
  logic [31:0] seen [64];
  logic [31:0] txw  [64];

  function automatic logic [31:0] bmask(int n);
    return (n >= 32) ? 32'hFFFF_FFFF : ((32'h1 << n) - 1);
  endfunction

  function automatic logic [31:0] slave_word(int k);
    return (32'h6b2f_91d3 ^ (32'(k) * 32'h0101_2749)) & bmask(s_len);
  endfunction

  function automatic logic sbit(int d);
    logic [31:0] w;
    w = slave_word(d / s_len);
    return w[s_len - 1 - (d % s_len)];
  endfunction

  function automatic logic [31:0] mk_ctrl(bit en, bit cpol, bit cpha, int dv, int len);
    return {19'b0, 5'(len - 1), 3'(dv), cpha, cpol, 1'b1, 1'b1, en};
  endfunction

  function automatic int span_expect(int len, int n, int dv);
    return (2 * len * n - 1) * (1 << (dv + 1));
  endfunction

  task automatic take_sample();
    s_cap = {s_cap[30:0], mosi};
    s_smp++;
    if (s_smp % s_len == 0 && n_seen < 64) begin
      seen[n_seen] = s_cap & bmask(s_len);
      n_seen++;
    end
  endtask

  always @(sclk) begin
    if (s_act && !cs_n) begin
      if (s_edges == 0) t_first = $time;
      t_last = $time;
      s_edges++;
      if (sclk != s_cpol) begin
        if (!s_cpha) take_sample();
        else begin miso = sbit(s_drv); s_drv++; end
      end else begin
        if (!s_cpha) begin miso = sbit(s_drv); s_drv++; end
        else take_sample();
      end
    end
  end

  // ---------------- bus and check helpers ----------------
  task automatic bus_wr(input logic [2:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr_en = 1'b1;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic bus_rd(input logic [2:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd_en = 1'b1;
    #2 d = rdata;
    @(negedge clk); rd_en = 1'b0;
  endtask

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", req, act, exp);
    end
  endtask

  task automatic wait_idle();
    logic [31:0] st;
    for (int i = 0; i < 40000; i++) begin
      bus_rd(3'd3, st);
      if (st[2] && !st[3]) break;
    end
  endtask

  task automatic slave_start(bit cpol, bit cpha, int len);
    repeat (3) @(negedge clk);
    s_cpol = cpol; s_cpha = cpha; s_len = len;
    s_drv = 0; s_smp = 0; s_edges = 0; n_seen = 0; s_cap = '0;
    bus_wr(3'd4, 32'd0);
    if (!cpha) begin miso = sbit(0); s_drv = 1; end
    s_act = 1;
  endtask

  task automatic slave_stop();
    bus_wr(3'd4, 32'd1);
    s_act = 0;
  endtask

  // full transfer: queue with enable low, then enable and compare
  task automatic run_xfer(bit cpol, bit cpha, int dv, int len, int n);
    logic [31:0] d;
    bus_wr(3'd2, mk_ctrl(0, cpol, cpha, dv, len));
    slave_start(cpol, cpha, len);
    for (int k = 0; k < n; k++) begin
      txw[k] = $urandom;
      bus_wr(3'd0, txw[k]);
    end
    bus_wr(3'd2, mk_ctrl(1, cpol, cpha, dv, len));
    wait_idle();
    chk("R6 edge span", 32'((t_last - t_first) / 8), 32'(span_expect(len, n, dv)));
    chk("R3 sclk idle", 32'(sclk), 32'(cpol));
    chk("R7 word count", 32'(n_seen), 32'(n));
    for (int k = 0; k < n; k++) begin
      bus_rd(3'd1, d);
      chk("R5 rx word", d, slave_word(k));
      chk("R4 mosi word", seen[k], txw[k] & bmask(len));
    end
    bus_rd(3'd3, d);
    chk("R7 rx drained", 32'(d[0]), 32'd0);
    slave_stop();
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #(8 * 190000);
    if (!finished) begin
      fails++;
      $display("FAIL R7 watchdog act=running exp=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- main sequence ----------------
  initial begin
    logic [31:0] d;
    void'($urandom(32'h5eed_2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 / R12 reset state
    bus_rd(3'd3, d); chk("R1 status", d, 32'h4);
    bus_rd(3'd2, d); chk("R1 ctrl", d, 32'h0);
    chk("R1 sclk", 32'(sclk), 32'd0);
    chk("R1 mosi", 32'(mosi), 32'd0);
    chk("R12 cs_n reset", 32'(cs_n), 32'd1);
    bus_wr(3'd4, 32'd0); chk("R12 cs_n low", 32'(cs_n), 32'd0);
    bus_wr(3'd4, 32'd1); chk("R12 cs_n high", 32'(cs_n), 32'd1);

    // R10 empty read
    bus_rd(3'd1, d); chk("R10 empty read", d, 32'h0);
    bus_rd(3'd3, d); chk("R10 udf set", 32'(d[5]), 32'd1);
    bus_wr(3'd3, 32'h20);
    bus_rd(3'd3, d); chk("R10 udf clear", 32'(d[5]), 32'd0);

    // R8 disabled controller holds words
    bus_wr(3'd2, mk_ctrl(0, 1, 0, 0, 8));
    slave_start(1, 0, 8);
    txw[0] = 32'hA5; bus_wr(3'd0, txw[0]);
    txw[1] = 32'h3C; bus_wr(3'd0, txw[1]);
    repeat (60) @(negedge clk);
    chk("R8 sclk idle", 32'(sclk), 32'd1);
    chk("R8 no edges", 32'(s_edges), 32'd0);
    bus_rd(3'd3, d);
    chk("R8 tx kept", 32'(d[2]), 32'd0);
    chk("R8 no rx", 32'(d[0]), 32'd0);
    bus_wr(3'd2, mk_ctrl(1, 1, 0, 0, 8));
    wait_idle();
    chk("R6 span two words", 32'((t_last - t_first) / 8), 32'(span_expect(8, 2, 0)));
    for (int k = 0; k < 2; k++) begin
      bus_rd(3'd1, d);
      chk("R7 rx after enable", d, slave_word(k));
      chk("R4 mosi after enable", seen[k], txw[k]);
    end
    slave_stop();

    // directed: slowest divider, 1-bit and 32-bit words
    run_xfer(0, 1, 7, 2, 2);
    run_xfer(1, 1, 0, 1, 3);
    run_xfer(0, 0, 1, 32, 2);

    // constrained random across all four modes
    for (int i = 0; i < 12; i++) begin
      run_xfer(i[0], i[1], int'($urandom_range(0, 3)), int'($urandom_range(1, 32)),
               int'($urandom_range(1, 6)));
    end

    // R9 overflow
    bus_wr(3'd2, mk_ctrl(0, 0, 0, 0, 8));
    slave_start(0, 0, 8);
    for (int k = 0; k < 17; k++) begin
      txw[k] = $urandom;
      bus_wr(3'd0, txw[k]);
    end
    bus_rd(3'd3, d);
    chk("R9 full bit", 32'(d[1]), 32'd1);
    chk("R9 ovf set", 32'(d[4]), 32'd1);
    bus_wr(3'd3, 32'h10);
    bus_rd(3'd3, d);
    chk("R9 ovf clear", 32'(d[4]), 32'd0);
    bus_wr(3'd2, mk_ctrl(1, 0, 0, 0, 8));
    wait_idle();
    chk("R9 16 words sent", 32'(n_seen), 32'd16);
    for (int k = 0; k < 16; k++) begin
      bus_rd(3'd1, d);
      chk("R9 rx order", d, slave_word(k));
      chk("R9 mosi order", seen[k], txw[k] & 32'hFF);
    end
    slave_stop();

    // R11 receive FIFO full stalls the engine
    bus_wr(3'd2, mk_ctrl(0, 0, 1, 0, 8));
    slave_start(0, 1, 8);
    for (int k = 0; k < 16; k++) begin
      txw[k] = $urandom;
      bus_wr(3'd0, txw[k]);
    end
    bus_wr(3'd2, mk_ctrl(1, 0, 1, 0, 8));
    wait_idle();
    txw[16] = $urandom; bus_wr(3'd0, txw[16]);
    txw[17] = $urandom; bus_wr(3'd0, txw[17]);
    repeat (200) @(negedge clk);
    bus_rd(3'd3, d);
    chk("R11 tx held", 32'(d[2]), 32'd0);
    chk("R11 not busy", 32'(d[3]), 32'd0);
    chk("R11 16 sent", 32'(n_seen), 32'd16);
    for (int k = 0; k < 18; k++) begin
      bus_rd(3'd1, d);
      chk("R11 rx order", d, slave_word(k));
      repeat (80) @(negedge clk);
    end
    chk("R11 all sent", 32'(n_seen), 32'd18);
    chk("R11 last mosi", seen[17], txw[17] & 32'hFF);
    bus_rd(3'd3, d);
    chk("R11 drained", d & 32'hF, 32'h4);
    slave_stop();

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule